// File: doc/BRIEF.md
# Fourteen-Channel 8-bit PWM DAC Bank

The block turns fourteen 8-bit duty values into fourteen pulse-width-modulated outputs. All of them are timed by one free-running 8-bit count, so every channel has a period of 256 clocks, which is 31.25 kHz at an 8 MHz clock. After an external RC filter, the fraction of each period that an output stays high sets an analog level. Each output is presented as an open-drain pull-low enable. When that signal is 1, the pin is pulled to ground. When it is 0, the pin is released and reads as high.

Software reaches the fourteen duty registers and one pin-select register over a small register bus. Writes are synchronous and reads are combinational. The first eight channels always own their pins. The other six share their pins with a general-purpose port, and an active-low select bit per channel decides who drives the pin. A duty value written by software is held aside and moves into the compare stage only when the count wraps, so a period is never cut short or stretched.

Top module: `pwm_dac_bank`

## Requirements
- R1: A shared 8-bit count starts at 0 after reset and advances by one every clock, wrapping from 255 to 0. Every channel therefore repeats with a period of 256 clocks.
- R2: In the clock where the count equals c, a channel's output is released (pull-low = 0) if c is below the channel's active duty value. Otherwise it is pulled low. A duty of 01h therefore gives exactly one high clock per period.
- R3: A duty value of 00h keeps the output pulled low for all 256 clocks of a period.
- R4: A duty value of FFh gives 255 released clocks and one pulled-low clock (count 255) per period.
- R5: Synchronous active-low reset sets the count to 0, every duty register and its active copy to 80h (128 high clocks per period), and the pin-select register to FFh.
- R6: Bus address k (0 to 13) writes and reads duty register k. Address 14 writes and reads the 8-bit pin-select register. Address 15 reads 00h, and a write to it changes no register.
- R7: A written duty value becomes active only at the clock where the count goes from 255 to 0. A write taken in the same clock as that wrap is seen one full period later.
- R8: For channel 8+j (j = 0..5), bit j of the pin-select register chooses the pin driver. With the bit at 0 the pin carries the PWM output. With the bit at 1 the pin carries port_pull_low[j].
- R9: Channels 0 to 7 always drive their pins from the PWM compare, whatever the pin-select register holds. Bits 7:6 of that register are stored and read back but affect no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Register address: 0-13 duty, 14 pin select |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| port_pull_low | input | 6 | Pull-low requests from the I/O port for the six shared pins |
| pin_pull_low | output | 14 | Pull-low enable per pin, 1 = drive ground |

## Verification
A software write to a duty register and the wrap of the shared count can land in the same clock. The hardware must then load the old value into the compare stage and keep the new one for the following period. The bench provokes this by tracking the count in its own model and issuing a write exactly while the count reads 255. It then counts the high clocks in each of the next two periods: the first must match the old duty and the second the new one. The per-clock reference model also compares every pin and the read data in every cycle, so a write that leaked into the current period would show up at once.

// File: rtl/pwm_dac_pkg.sv
// Package: shared widths, reset values and register addresses for the PWM DAC bank.
// Assumes an 8-bit duty resolution and a 4-bit register address space.
package pwm_dac_pkg;
    localparam int DUTY_W        = 8;
    localparam int ADDR_W        = 4;
    localparam int NUM_CH        = 14;
    localparam int NUM_SHARED    = 6;
    localparam logic [DUTY_W-1:0] DUTY_RST = 8'h80;
    localparam logic [DUTY_W-1:0] SEL_RST  = 8'hFF;
    localparam logic [DUTY_W-1:0] RD_NONE  = 8'h00;
endpackage

// File: rtl/pwm_base_counter.sv
// Module: free-running period counter shared by all channels.
// Assumes the period is 2**WIDTH clocks; flags the last count of each period.
module pwm_base_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] count,
    output logic             last_tick
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic [WIDTH-1:0] count_q;

    // Advance the count every clock; wrap is natural modulo 2**WIDTH.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_q + 1'b1;
    end

    assign count     = count_q;
    assign last_tick = (count_q == TOP);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (count_q == WIDTH'($past(count_q) + 1'b1))); // R1
    AST_COUNT_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (count_q == '0)); // R5
endmodule

// File: rtl/pwm_channel.sv
// Module: one PWM channel: software-visible duty register, active compare copy
// loaded at the period boundary, and the level comparator.
// Assumes the shared counter flags its last count one clock before the wrap.
module pwm_channel #(
    parameter int                WIDTH   = 8,
    parameter logic [WIDTH-1:0]  RST_VAL = 8'h80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] count,
    input  logic             last_tick,
    output logic [WIDTH-1:0] duty,
    output logic             level_hi
);
    logic [WIDTH-1:0] duty_q;
    logic [WIDTH-1:0] active_q;

    // Capture software writes into the holding duty register.
    always_ff @(posedge clk) begin
        if (!rst_n)      duty_q <= RST_VAL;
        else if (wr_stb) duty_q <= wr_data;
    end

    // Move the held duty into the compare stage only as the period wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)         active_q <= RST_VAL;
        else if (last_tick) active_q <= duty_q;
    end

    // Output is high while the count is below the active duty.
    always_comb begin
        level_hi = (count < active_q);
    end

    assign duty = duty_q;

    AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(last_tick)) |-> $stable(active_q)); // R7
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (duty_q == $past(wr_data))); // R6
    AST_DUTY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (duty_q == RST_VAL && active_q == RST_VAL)); // R5
    AST_FULL_LOW_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        last_tick |-> !level_hi); // R4
    AST_ZERO_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q == '0) |-> !level_hi); // R3
endmodule

// File: rtl/pwm_pin_mux.sv
// Module: routes PWM levels to open-drain pull-low enables; the upper channels
// may hand their pins to the I/O port under an active-low select.
// Assumes the dedicated channels occupy the low indices.
module pwm_pin_mux #(
    parameter int NUM_CH     = 14,
    parameter int NUM_SHARED = 6
) (
    input  logic [NUM_CH-1:0]     level_hi,
    input  logic [NUM_SHARED-1:0] port_sel,
    input  logic [NUM_SHARED-1:0] port_pull_low,
    output logic [NUM_CH-1:0]     pin_pull_low
);
    localparam int NUM_DED = NUM_CH - NUM_SHARED;

    genvar i;
    generate
        for (i = 0; i < NUM_CH; i++) begin : g_pin
            if (i < NUM_DED) begin : g_ded
                // Dedicated pin: always the inverted PWM level.
                assign pin_pull_low[i] = ~level_hi[i];
            end else begin : g_shr
                // Shared pin: select bit 1 gives the pin to the port.
                assign pin_pull_low[i] = port_sel[i-NUM_DED] ? port_pull_low[i-NUM_DED]
                                                             : ~level_hi[i];
            end
        end
    endgenerate
endmodule

// File: rtl/pwm_dac_bank.sv
// Module: top of the PWM DAC bank: register decode, channel array, shared
// counter and pin routing. Assumes a single-clock register bus with
// combinational read data.
module pwm_dac_bank
    import pwm_dac_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [DUTY_W-1:0]     bus_wdata,
    output logic [DUTY_W-1:0]     bus_rdata,
    input  logic [NUM_SHARED-1:0] port_pull_low,
    output logic [NUM_CH-1:0]     pin_pull_low
);
    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(NUM_CH);

    logic [DUTY_W-1:0] count;
    logic              last_tick;
    logic [DUTY_W-1:0] duty_rd [NUM_CH];
    logic [NUM_CH-1:0] level_hi;
    logic [DUTY_W-1:0] sel_q;

    pwm_base_counter #(.WIDTH(DUTY_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (count),
        .last_tick (last_tick)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            pwm_channel #(.WIDTH(DUTY_W), .RST_VAL(DUTY_RST)) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_stb    (bus_wr && (bus_addr == ADDR_W'(c))),
                .wr_data   (bus_wdata),
                .count     (count),
                .last_tick (last_tick),
                .duty      (duty_rd[c]),
                .level_hi  (level_hi[c])
            );
        end
    endgenerate

    // Hold the pin-select register; bits above the shared count are storage only.
    always_ff @(posedge clk) begin
        if (!rst_n)                              sel_q <= SEL_RST;
        else if (bus_wr && bus_addr == SEL_ADDR) sel_q <= bus_wdata;
    end

    // Decode read data: duty registers, then select register, else zero.
    always_comb begin
        if (bus_addr < SEL_ADDR)       bus_rdata = duty_rd[bus_addr];
        else if (bus_addr == SEL_ADDR) bus_rdata = sel_q;
        else                           bus_rdata = RD_NONE;
    end

    pwm_pin_mux #(.NUM_CH(NUM_CH), .NUM_SHARED(NUM_SHARED)) u_mux (
        .level_hi      (level_hi),
        .port_sel      (sel_q[NUM_SHARED-1:0]),
        .port_pull_low (port_pull_low),
        .pin_pull_low  (pin_pull_low)
    );

    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr > SEL_ADDR) |=> $stable(sel_q)); // R6
    AST_SEL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (sel_q == SEL_RST)); // R5
    AST_PORT_OWNS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q[0] |-> (pin_pull_low[NUM_CH-NUM_SHARED] == port_pull_low[0])); // R8
endmodule

// File: tb/sim_pwm_dac_bank.sv
module sim_pwm_dac_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [5:0]  port_pull_low = 6'b101010;
    logic [13:0] pin_pull_low;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // Reference model state
    int m_cnt = 0;
    int m_duty [14];
    int m_act  [14];
    int m_sel  = 255;

    pwm_dac_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_pull_low(port_pull_low), .pin_pull_low(pin_pull_low)
    );

    always #5 clk = ~clk;

    // Behavioural model: updates from old state at each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_sel = 255;
            for (int i = 0; i < 14; i++) begin m_duty[i] = 128; m_act[i] = 128; end
        end else begin
            if (m_cnt == 255)
                for (int i = 0; i < 14; i++) m_act[i] = m_duty[i];
            if (bus_wr && bus_addr < 14) m_duty[bus_addr] = bus_wdata;
            if (bus_wr && bus_addr == 14) m_sel = bus_wdata;
            m_cnt = (m_cnt + 1) % 256;
        end
    end

    function automatic bit exp_pin(int i);
        if (i >= 8 && m_sel[i-8]) return port_pull_low[i-8];
        return !(m_cnt < m_act[i]);
    endfunction

    function automatic int exp_rd();
        if (bus_addr < 14) return m_duty[bus_addr];
        if (bus_addr == 14) return m_sel;
        return 0;
    endfunction

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < 14; i++) begin
                checks++;
                if (pin_pull_low[i] !== exp_pin(i)) begin
                    fails++;
                    $display("FAIL %s pin %0d cnt %0d: actual %0b expected %0b",
                             (i < 8) ? "R2/R9" : "R2/R8", i, m_cnt, pin_pull_low[i], exp_pin(i));
                end
            end
            checks++;
            if (bus_rdata !== 8'(exp_rd())) begin
                fails++;
                $display("FAIL R6 read addr %0d: actual %02h expected %02h",
                         bus_addr, bus_rdata, exp_rd());
            end
        end
    end

    task automatic chk(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_addr = 4'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(string req, int a, int expv);
        @(negedge clk);
        bus_addr = 4'(a);
        #1;
        chk(req, int'(bus_rdata), expv);
    endtask

    // Count released clocks of one channel over one full period from count 0.
    task automatic high_count(int ch, output int n);
        n = 0;
        do @(negedge clk); while (m_cnt != 0);
        for (int k = 0; k < 256; k++) begin
            if (!pin_pull_low[ch]) n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        int start;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R5: reset state at ports
        for (int a = 0; a < 14; a++) chk("R5 duty reset", int'(u0.bus_rdata), 128);
        rd("R5 select reset", 14, 255);
        chk("R5 shared pin follows port", int'(pin_pull_low[13:8]), int'(port_pull_low));
        high_count(0, n); chk("R5 half duty", n, 128);
        // R1: period 256: released run starts again exactly 256 clocks later
        do @(negedge clk); while (m_cnt != 0);
        start = cycles;
        do @(negedge clk); while (m_cnt != 0);
        chk("R1 period", cycles - start, 256);
        // R2/R3/R4 duty patterns
        wr(1, 8'h00); wr(2, 8'hFF); wr(3, 8'h01); wr(4, 8'h40);
        high_count(1, n); chk("R3 zero duty", n, 0);
        high_count(2, n); chk("R4 full duty", n, 255);
        high_count(3, n); chk("R2 one clock", n, 1);
        high_count(4, n); chk("R2 quarter", n, 64);
        // R8/R9: enable some shared channels, select register also set for low bits
        wr(14, 8'b0001_0101);
        rd("R6 select readback", 14, 8'h15);
        wr(9, 8'h00);
        high_count(9, n); chk("R8 shared PWM zero duty", n, 0);
        port_pull_low = 6'b000000;
        high_count(8, n); chk("R8 port owns pin", n, 256);
        wr(14, 8'hC0);
        high_count(0, n); chk("R9 dedicated unaffected", n, 128);
        high_count(9, n); chk("R8 shared enabled", n, 0);
        // R7: write coincident with wrap
        wr(5, 8'h20);
        high_count(5, n);
        do @(negedge clk); while (m_cnt != 255);
        bus_addr = 4'd5; bus_wdata = 8'h90; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        n = 0;
        for (int k = 0; k < 256; k++) begin
            if (!pin_pull_low[5]) n++;
            if (k < 255) @(negedge clk);
        end
        chk("R7 wrap write deferred", n, 32);
        high_count(5, n); chk("R7 new duty next period", n, 144);
        // R6: unmapped address
        wr(15, 8'h00);
        rd("R6 unmapped reads zero", 15, 0);
        rd("R6 select untouched", 14, 8'hC0);
        // mixed writes checked by the model
        for (int k = 0; k < 40; k++) begin
            wr(k % 15, (k * 37 + 11) % 256);
            port_pull_low = 6'((k * 13) % 64);
            repeat (k * 7 % 50) @(negedge clk);
        end
        repeat (300) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        fails++;
        done = 1'b1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule